// File: doc/BRIEF.md
# Suspend Wake Event Controller

This block manages entry into and exit from a low-power suspend state. A mode register selects one of four suspend modes. Each mode has a fixed set of wake sources that may raise a remote wakeup. Five event pulses come from logic outside the block: GPIO, pattern-match wake, magic packet, link change and good packet. While the block is suspended, it passes only the events that the current mode accepts. The first accepted event raises a wakeup request and records which sources caused it.

The block also drives the MAC clock enable. Only the deepest mode stops the MAC clock while suspended. The enable comes back on the cycle the block returns to normal operation.

The controller has three states, all named `ST_NORMAL`, `ST_ASLEEP` and `ST_WAKE`:
- `ST_NORMAL` goes to `ST_ASLEEP` on a suspend request.
- `ST_ASLEEP` goes to `ST_WAKE` on an accepted event.
- `ST_ASLEEP` goes to `ST_NORMAL` on a resume acknowledge that arrives with no wake.
- `ST_WAKE` goes to `ST_NORMAL` on a resume acknowledge.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset, `wake_req` is 0, `mac_clk_en` is 1, `wake_status` is 0 and the mode register holds mode 2.
- R2: A pulse on `mode_set` in `ST_NORMAL` loads `mode_sel` into the mode register. A suspend request in the same cycle uses the new value. In `ST_ASLEEP` and `ST_WAKE`, `mode_set` is ignored and the mode stays frozen.
- R3: `suspend_req` in `ST_NORMAL` moves the block to `ST_ASLEEP` and clears `wake_status`.
- R4: Event bit positions in `ev_in` and `wake_status` are: bit0 GPIO, bit1 pattern wake, bit2 magic packet, bit3 link change, bit4 good packet. The accepted sets per mode are:
  - mode 0: bits 0, 1 and 2 (mask 5'b00111)
  - mode 1: bits 0 and 3 (mask 5'b01001)
  - mode 2: bit 0 only (mask 5'b00001)
  - mode 3: bits 0 and 4 (mask 5'b10001)
- R5: Events outside the current mode's mask are ignored and never latched. All events are ignored in `ST_NORMAL`.
- R6: In `ST_ASLEEP`, a cycle with any accepted event moves the block to `ST_WAKE`. The accepted bits of that cycle are latched into `wake_status`, and `wake_req` is 1 from the next cycle. Later events do not change `wake_status`.
- R7: `wake_req` stays 1 until `resume_ack`, which returns the block to `ST_NORMAL`. `wake_status` keeps its value until the next suspend.
- R8: `mac_clk_en` is 0 in `ST_ASLEEP` and `ST_WAKE` only when the mode is 0. It is 1 again in the first cycle back in `ST_NORMAL`.
- R9: `resume_ack` in `ST_ASLEEP` returns the block to `ST_NORMAL` with `wake_req` still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Suspend mode value to load |
| mode_set | input | 1 | Load strobe for mode_sel |
| suspend_req | input | 1 | Request to enter suspend |
| resume_ack | input | 1 | Host resume acknowledge |
| ev_in | input | 5 | Wake event pulses, bit order per R4 |
| wake_req | output | 1 | Remote wakeup request |
| mac_clk_en | output | 1 | MAC clock enable |
| wake_status | output | 5 | Latched wake sources |

## Verification
The assertions check four behaviours on every cycle:
- the wakeup request holds until acknowledged;
- latched status is frozen and non-zero while waking;
- no status bit lies outside the frozen mode's mask;
- the MAC clock is stopped only in mode 0 and comes back right after an acknowledge.

Only the bench's sweeps can show the full mask table, because it needs every mode crossed with every event pattern. The same holds for status clearing on suspend entry, the default mode after reset and mode writes being ignored while suspended.

// File: rtl/susp_wake_pkg.sv
package susp_wake_pkg;
    localparam int NUM_SRC = 5;
    localparam int MODE_W  = 2;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WAKE   = 2'd2
    } wake_state_t;

    // R4: wake-source mask for each suspend mode
    function automatic logic [NUM_SRC-1:0] mode_mask(input logic [MODE_W-1:0] m);
        logic [NUM_SRC-1:0] k;
        k = 5'b00001;
        unique case (m)
            2'd0: k = k | 5'b00110;
            2'd1: k = k | 5'b01000;
            2'd2: k = k;
            2'd3: k = k | 5'b10000;
        endcase
        return k;
    endfunction

    function automatic logic mode_stops_clk(input logic [MODE_W-1:0] m);
        return (m == '0);
    endfunction
endpackage

// File: rtl/susp_mode_reg.sv
module susp_mode_reg
    import susp_wake_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter logic [MW-1:0] DEFAULT_MODE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_normal,
    input  logic          mode_set,
    input  logic [MW-1:0] mode_sel,
    output logic [MW-1:0] mode_eff,
    output logic [MW-1:0] mode_q
);
    // A write in the same cycle as a suspend request takes effect at once
    always_comb mode_eff = (in_normal && mode_set) ? mode_sel : mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= DEFAULT_MODE;
        else if (in_normal && mode_set)
            mode_q <= mode_sel;
    end
endmodule

// File: rtl/wake_src_filter.sv
module wake_src_filter
    import susp_wake_pkg::*;
#(
    parameter int NS = NUM_SRC
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [NS-1:0]     ev_in,
    output logic [NS-1:0]     hit_vec,
    output logic              hit_any
);
    logic [NS-1:0] mask;

    always_comb mask = mode_mask(mode);

    for (genvar i = 0; i < NS; i++) begin : g_src
        assign hit_vec[i] = ev_in[i] & mask[i];
    end

    assign hit_any = |hit_vec;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import susp_wake_pkg::*;
#(
    parameter int NS = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          suspend_req,
    input  logic          resume_ack,
    input  logic          hit_any,
    input  logic [NS-1:0] hit_vec,
    output wake_state_t   state,
    output logic          in_normal,
    output logic          asleep,
    output logic          wake_req,
    output logic [NS-1:0] status
);
    wake_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: if (suspend_req) state_nx = ST_ASLEEP;
            ST_ASLEEP: begin
                if (hit_any)         state_nx = ST_WAKE;
                else if (resume_ack) state_nx = ST_NORMAL;
            end
            ST_WAKE:   if (resume_ack) state_nx = ST_NORMAL;
            default:   state_nx = ST_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nx;
    end

    // Wake-source latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (state == ST_NORMAL && suspend_req)
            status <= '0;
        else if (state == ST_ASLEEP && hit_any)
            status <= hit_vec;
    end

    // Outputs decoded from state
    always_comb begin
        in_normal = (state == ST_NORMAL);
        asleep    = (state != ST_NORMAL);
        wake_req  = (state == ST_WAKE);
    end
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
    import susp_wake_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int MW = MODE_W,
    parameter logic [MW-1:0] DEFAULT_MODE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_sel,
    input  logic          mode_set,
    input  logic          suspend_req,
    input  logic          resume_ack,
    input  logic [NS-1:0] ev_in,
    output logic          wake_req,
    output logic          mac_clk_en,
    output logic [NS-1:0] wake_status
);
    wake_state_t   state;
    logic          in_normal, asleep, hit_any;
    logic [MW-1:0] mode_q, mode_eff;
    logic [NS-1:0] hit_vec;

    susp_mode_reg #(.MW(MW), .DEFAULT_MODE(DEFAULT_MODE)) u_mode (
        .clk(clk), .rst_n(rst_n), .in_normal(in_normal),
        .mode_set(mode_set), .mode_sel(mode_sel),
        .mode_eff(mode_eff), .mode_q(mode_q)
    );

    wake_src_filter #(.NS(NS)) u_filt (
        .mode(mode_q), .ev_in(ev_in),
        .hit_vec(hit_vec), .hit_any(hit_any)
    );

    wake_fsm #(.NS(NS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
        .resume_ack(resume_ack), .hit_any(hit_any), .hit_vec(hit_vec),
        .state(state), .in_normal(in_normal), .asleep(asleep),
        .wake_req(wake_req), .status(wake_status)
    );

    // The mode is frozen while suspended, so mode_q is the active mode here
    always_comb mac_clk_en = !(asleep && mode_stops_clk(mode_q));

    logic unused_eff;
    assign unused_eff = ^mode_eff;
endmodule

// File: rtl/susp_wake_chk.sv
module susp_wake_chk
    import susp_wake_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                resume_ack,
    input logic                wake_req,
    input logic                mac_clk_en,
    input logic [NUM_SRC-1:0]  wake_status,
    input logic [MODE_W-1:0]   mode_q
);
    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !resume_ack) |=> wake_req);

    // R6
    status_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && $past(wake_req)) |-> $stable(wake_status));

    // R6
    status_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (wake_status != '0));

    // R5
    status_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((wake_status & ~mode_mask(mode_q)) == '0));

    // R8
    clk_gate_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_clk_en |-> (mode_q == '0));

    // R8
    clk_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && resume_ack) |=> mac_clk_en);
endmodule

bind susp_wake_ctrl susp_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .resume_ack(resume_ack),
    .wake_req(wake_req), .mac_clk_en(mac_clk_en),
    .wake_status(wake_status), .mode_q(mode_q)
);

// File: tb/sim_susp_wake_ctrl.sv
`timescale 1ns/1ps
module sim_susp_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic [1:0] mode_sel = 0;
    logic       mode_set = 0, suspend_req = 0, resume_ack = 0;
    logic [4:0] ev_in = 0;
    logic       wake_req, mac_clk_en;
    logic [4:0] wake_status;
    int         n_run = 0, n_fail = 0, cyc_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    susp_wake_ctrl u0 (.*);

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_mask(input int m);
        return 5'd1 | (m == 0 ? 5'd6 : 5'd0) | (m == 1 ? 5'd8 : 5'd0)
                    | (m == 3 ? 5'd16 : 5'd0);
    endfunction

    task automatic pulse_ev(input logic [4:0] p);
        ev_in = p; cyc(); ev_in = 0;
    endtask

    task automatic ack();
        resume_ack = 1; cyc(); resume_ack = 0;
    endtask

    task automatic sleep();
        suspend_req = 1; cyc(); suspend_req = 0;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); rst_n = 1; cyc();
        // R1 reset values
        chk("R1 wake_req", wake_req, 0);
        chk("R1 mac_clk_en", mac_clk_en, 1);
        chk("R1 wake_status", wake_status, 0);
        // R5 events in normal state are ignored
        pulse_ev(5'h1F);
        chk("R5 normal ignore", {27'd0, wake_status, wake_req}, 0);
        // R1 default mode 2: pattern wake ignored, GPIO accepted
        sleep();
        chk("R1 mode2 clk", mac_clk_en, 1);
        pulse_ev(5'b00010);
        chk("R1 mode2 rejects bit1", wake_req, 0);
        // R2 mode write ignored while asleep
        mode_sel = 0; mode_set = 1; cyc(); mode_set = 0;
        chk("R2 frozen clk", mac_clk_en, 1);
        pulse_ev(5'b00100);
        chk("R2 frozen mask", wake_req, 0);
        pulse_ev(5'b00001);
        chk("R1 mode2 gpio", wake_req, 1);
        chk("R6 status gpio", wake_status, 1);
        ack();
        chk("R7 release", wake_req, 0);

        // R2 same-cycle write and suspend
        mode_sel = 0; mode_set = 1; suspend_req = 1; cyc();
        mode_set = 0; suspend_req = 0;
        chk("R2 same cycle clk", mac_clk_en, 0);
        ack();
        chk("R9 ack asleep", {30'd0, mac_clk_en, wake_req}, 2);

        // Sweep every mode against every event pattern
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 32; p++) begin
                logic [4:0] e;
                e = 5'(p) & exp_mask(m);
                mode_sel = 2'(m); mode_set = 1; cyc(); mode_set = 0;
                sleep();
                chk("R3 status cleared", wake_status, 0);
                chk("R8 clk asleep", mac_clk_en, (m != 0) ? 1 : 0);
                pulse_ev(5'(p));
                if (e != 0) begin
                    chk("R6 wake_req", wake_req, 1);
                    chk("R4 R6 status", wake_status, e);
                    pulse_ev(5'h1F);
                    chk("R6 status held", wake_status, e);
                    chk("R7 req held", wake_req, 1);
                    chk("R8 clk waking", mac_clk_en, (m != 0) ? 1 : 0);
                    ack();
                    chk("R7 req drop", wake_req, 0);
                    chk("R8 clk restored", mac_clk_en, 1);
                    chk("R7 status kept", wake_status, e);
                end else begin
                    chk("R5 no wake", wake_req, 0);
                    chk("R5 not latched", wake_status, 0);
                    ack();
                    chk("R9 back normal", {30'd0, mac_clk_en, wake_req}, 2);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule